// File: doc/BRIEF.md
# Phase-Accumulator PWM Bank with Deferred Reload

This block is a bank of identical pulse-width generators, each programmed through one 32-bit control word on a simple write/read register port. Every channel owns a 16-bit phase accumulator. On every clock while the channel is on, the accumulator adds a programmable increment. One output period is one trip of the accumulator around its range, so the output frequency is the clock rate times the increment divided by 65536.

The duty is set by an 8-bit threshold. The output is high while the accumulator's upper byte is at or above the threshold, so a smaller threshold gives a longer high time.

Software writes a new increment and threshold into shadow storage. It then sets a self-clearing reload request. The hardware copies the shadow values into the working copy only at a period boundary, so a running waveform never shows a torn period. Channels sit at a fixed address stride, so one decoder serves one to four channels.

Top module: `pwm_phase_bank`

## Requirements
- R1: After reset, every channel's control word reads 0 and every `pwm_out` bit is low.
- R2: The control word layout is as follows.
  - Bit 31 is the channel-on flag, and it reads back as written.
  - Bit 30 reads 1 while a reload is pending.
  - Bits 23:8 read back the last written increment.
  - Bits 7:0 read back the last written threshold.
  - Bits 29:24 always read 0.
- R3: Channel c's control word sits at byte address c*0x400. A write to any address whose low 10 bits are not zero changes nothing, and a read from such an address returns 0.
- R4: While a channel is off, its output is low and its accumulator is held at zero. When the channel is switched on, the first period starts from accumulator value 0.
- R5: While a channel is on, its output is high in exactly the cycles where the upper 8 bits of the accumulator are greater than or equal to the working threshold.
  - A threshold of 0 gives a constant high output.
  - A threshold above the largest upper-byte value the accumulator reaches gives a constant low output.
- R6: While a channel is on, the accumulator advances by the working increment modulo 2^16 every clock. A carry out of bit 15 ends a period.
- R7: Writing a new increment or threshold with bit 30 clear changes only the shadow values. The running waveform keeps its working increment and threshold.
- R8: Writing bit 30 as 1 makes a reload pending. The working values are updated from the shadow values at the next boundary, which is either a carry out of the accumulator or a cycle with the accumulator at zero. Bit 30 clears in that same clock. On an off channel, the reload therefore takes effect on the next clock.
- R9: Channels are independent. Writing one channel never alters the output or the control word of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all channels |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_addr | input | ADDR_W | Byte address; the channel index sits above bit STRIDE_LSB-1 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pwm_out | output | NUM_CH | One pulse-width output per channel |

## Verification
The checker assumes that the write strobe and address are stable around the rising edge. It also assumes that a reload request is only ever raised through a write, so the pending flag can fall only on a boundary. The properties relate the working values to the shadow values at the moment of a reload, and they relate the accumulator to its previous value at a carry.

The stimulus keeps to these assumptions. It drives every write between edges and holds it for exactly one clock. It programs a channel's first settings while the channel is off. It chooses increments of 0x800 and 0x1000, which divide 2^16 evenly, so that a window of whole periods has a known high count whatever its phase. A single increment of 0x3000 is counted from accumulator zero.

// File: rtl/pwm_phase_pkg.sv
package pwm_phase_pkg;
  localparam int ACC_W   = 16;
  localparam int THR_W   = 8;
  localparam int WORD_W  = 32;
  localparam int ON_BIT  = 31;
  localparam int RLD_BIT = 30;
  localparam int INC_LSB = 8;
  localparam int THR_LSB = 0;

  // Accumulator step with carry out in the top bit.
  function automatic logic [ACC_W:0] acc_step(input logic [ACC_W-1:0] acc,
                                              input logic [ACC_W-1:0] inc);
    return {1'b0, acc} + {1'b0, inc};
  endfunction

  // Output level for a given phase and threshold.
  function automatic logic duty_hit(input logic [ACC_W-1:0] acc,
                                    input logic [THR_W-1:0] thr);
    return acc[ACC_W-1 -: THR_W] >= thr;
  endfunction
endpackage

// File: rtl/pwm_reg_slot.sv
module pwm_reg_slot
  import pwm_phase_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_sel,
  input  logic             wr_on,
  input  logic             wr_rld,
  input  logic [ACC_W-1:0] wr_inc,
  input  logic [THR_W-1:0] wr_thr,
  input  logic             commit,
  output logic             on_q,
  output logic             pend_q,
  output logic [ACC_W-1:0] inc_sh,
  output logic [THR_W-1:0] thr_sh
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q   <= 1'b0;
      pend_q <= 1'b0;
      inc_sh <= '0;
      thr_sh <= '0;
    end else if (wr_sel) begin
      on_q   <= wr_on;
      inc_sh <= wr_inc;
      thr_sh <= wr_thr;
      pend_q <= wr_rld | (pend_q & ~commit);
    end else if (commit) begin
      pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_phase_core.sv
module pwm_phase_core
  import pwm_phase_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             on_q,
  input  logic             pend_q,
  input  logic [ACC_W-1:0] inc_sh,
  input  logic [THR_W-1:0] thr_sh,
  output logic             commit,
  output logic             wrap,
  output logic [ACC_W-1:0] acc_q,
  output logic [ACC_W-1:0] inc_act,
  output logic [THR_W-1:0] thr_act,
  output logic             pwm
);
  logic [ACC_W:0] sum;
  logic           boundary;

  assign sum      = acc_step(acc_q, inc_act);
  assign wrap     = on_q & sum[ACC_W];
  assign boundary = wrap | (acc_q == '0);
  assign commit   = pend_q & boundary;
  assign pwm      = on_q & duty_hit(acc_q, thr_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      inc_act <= '0;
      thr_act <= '0;
    end else begin
      acc_q <= on_q ? sum[ACC_W-1:0] : '0;
      if (commit) begin
        inc_act <= inc_sh;
        thr_act <= thr_sh;
      end
    end
  end
endmodule

// File: rtl/pwm_phase_bank.sv
module pwm_phase_bank
  import pwm_phase_pkg::*;
#(
  parameter int NUM_CH     = 4,
  parameter int STRIDE_LSB = 10,
  parameter int ADDR_W     = STRIDE_LSB + ((NUM_CH > 1) ? $clog2(NUM_CH) : 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  localparam int SEL_W = ADDR_W - STRIDE_LSB;

  logic [SEL_W-1:0] sel_idx;
  logic             sel_ok;

  logic [NUM_CH-1:0]            ch_en, ch_pend, ch_commit, ch_wrap;
  logic [NUM_CH-1:0][ACC_W-1:0] ch_acc, ch_inc_act, ch_inc_sh;
  logic [NUM_CH-1:0][THR_W-1:0] ch_thr_act, ch_thr_sh;

  wire unused_wbits = ^bus_wdata[RLD_BIT-1:INC_LSB+ACC_W];

  assign sel_idx = bus_addr[ADDR_W-1:STRIDE_LSB];
  assign sel_ok  = (bus_addr[STRIDE_LSB-1:0] == '0) && (32'(sel_idx) < NUM_CH);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic wr_sel;
    assign wr_sel = bus_we & sel_ok & (sel_idx == SEL_W'(c));

    pwm_reg_slot u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_sel (wr_sel),
      .wr_on  (bus_wdata[ON_BIT]),
      .wr_rld (bus_wdata[RLD_BIT]),
      .wr_inc (bus_wdata[INC_LSB +: ACC_W]),
      .wr_thr (bus_wdata[THR_LSB +: THR_W]),
      .commit (ch_commit[c]),
      .on_q   (ch_en[c]),
      .pend_q (ch_pend[c]),
      .inc_sh (ch_inc_sh[c]),
      .thr_sh (ch_thr_sh[c])
    );

    pwm_phase_core u_core (
      .clk     (clk),
      .rst_n   (rst_n),
      .on_q    (ch_en[c]),
      .pend_q  (ch_pend[c]),
      .inc_sh  (ch_inc_sh[c]),
      .thr_sh  (ch_thr_sh[c]),
      .commit  (ch_commit[c]),
      .wrap    (ch_wrap[c]),
      .acc_q   (ch_acc[c]),
      .inc_act (ch_inc_act[c]),
      .thr_act (ch_thr_act[c]),
      .pwm     (pwm_out[c])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (sel_ok && sel_idx == SEL_W'(c)) begin
        bus_rdata[ON_BIT]             = ch_en[c];
        bus_rdata[RLD_BIT]            = ch_pend[c];
        bus_rdata[INC_LSB +: ACC_W]   = ch_inc_sh[c];
        bus_rdata[THR_LSB +: THR_W]   = ch_thr_sh[c];
      end
    end
  end
endmodule

// File: rtl/pwm_phase_checker.sv
module pwm_phase_checker
  import pwm_phase_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_CH-1:0]            ch_en,
  input logic [NUM_CH-1:0]            ch_pend,
  input logic [NUM_CH-1:0]            ch_commit,
  input logic [NUM_CH-1:0]            ch_wrap,
  input logic [NUM_CH-1:0][ACC_W-1:0] ch_acc,
  input logic [NUM_CH-1:0][ACC_W-1:0] ch_inc_act,
  input logic [NUM_CH-1:0][ACC_W-1:0] ch_inc_sh,
  input logic [NUM_CH-1:0][THR_W-1:0] ch_thr_act,
  input logic [NUM_CH-1:0][THR_W-1:0] ch_thr_sh,
  input logic [NUM_CH-1:0]            pwm_out
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    assert_idle_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_en[i] |=> ch_acc[i] == '0);

    assert_out_needs_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pwm_out[i] |-> ch_en[i]);

    assert_carry_wraps_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_en[i] && ch_wrap[i]) |=> ch_acc[i] < $past(ch_acc[i]));

    assert_shadow_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_commit[i] |=> ($stable(ch_inc_act[i]) && $stable(ch_thr_act[i])));

    assert_reload_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ch_commit[i] |=> (ch_inc_act[i] == $past(ch_inc_sh[i]) &&
                        ch_thr_act[i] == $past(ch_thr_sh[i])));

    assert_pend_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_pend[i] && !ch_commit[i]) |=> ch_pend[i]);

    assert_commit_needs_pend_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ch_commit[i] |-> ch_pend[i]);
  end
endmodule

bind pwm_phase_bank pwm_phase_checker #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ch_en      (ch_en),
  .ch_pend    (ch_pend),
  .ch_commit  (ch_commit),
  .ch_wrap    (ch_wrap),
  .ch_acc     (ch_acc),
  .ch_inc_act (ch_inc_act),
  .ch_inc_sh  (ch_inc_sh),
  .ch_thr_act (ch_thr_act),
  .ch_thr_sh  (ch_thr_sh),
  .pwm_out    (pwm_out)
);

// File: tb/sim_pwm_phase_bank.sv
`timescale 1ns/1ps
module sim_pwm_phase_bank;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] pwm_out;

  int n_checks = 0;
  int n_errors = 0;

  typedef struct { string tag; longint val; } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  pwm_phase_bank #(.NUM_CH(NCH), .STRIDE_LSB(10)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  // Driver side: post an expected value.
  task automatic expect_val(input string tag, input longint v);
    exp_t e;
    e.tag = tag; e.val = v;
    exp_q.push_back(e);
  endtask

  // Monitor side: pop the oldest expectation and compare.
  task automatic observe(input longint act);
    exp_t e;
    n_checks++;
    if (exp_q.size() == 0) begin
      n_errors++;
      $display("FAIL scoreboard empty, actual %0h", act);
    end else begin
      e = exp_q.pop_front();
      if (act != e.val) begin
        n_errors++;
        $display("FAIL %s actual=%0h expected=%0h", e.tag, act, e.val);
      end
    end
  endtask

  // High cycles from step k0 to k0+n-1, phase restarting from zero.
  function automatic longint high_count(input longint inc, input longint thr,
                                        input longint k0, input longint n);
    longint cnt = 0;
    for (longint k = k0; k < k0 + n; k++) begin
      longint ph = (k * inc) % 65536;
      if ((ph / 256) >= thr) cnt++;
    end
    return cnt;
  endfunction

  function automatic logic [31:0] word(input bit on, input bit rld,
                                       input int inc, input int thr);
    return {on, rld, 6'b0, inc[15:0], thr[7:0]};
  endfunction

  task automatic wr(input int addr, input logic [31:0] d);
    bus_addr = addr[11:0]; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int addr, output logic [31:0] d);
    bus_addr = addr[11:0];
    #1;
    d = bus_rdata;
  endtask

  task automatic measure(input int ch, input int n, output longint cnt);
    cnt = 0;
    for (int k = 0; k < n; k++) begin
      if (pwm_out[ch]) cnt++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] r;
    longint cnt;
    int wait_n;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int c = 0; c < NCH; c++) begin
      expect_val("R1 reset word", 0); rd(c * 'h400, r); observe(r);
    end
    expect_val("R1 outputs low", 0); observe(pwm_out);

    // R8/R2: reload on off channel, pending visible then cleared next clock
    wr('h000, word(0, 1, 'h1000, 'h80));
    expect_val("R8 pending after write", word(0, 1, 'h1000, 'h80));
    rd('h000, r); observe(r);
    @(negedge clk);
    expect_val("R2 field readback", word(0, 0, 'h1000, 'h80));
    rd('h000, r); observe(r);

    // R4: off channel stays low
    expect_val("R4 off output low", 0); measure(0, 8, cnt); observe(cnt);

    // R4/R5/R6: switch on, phase starts at zero
    wr('h000, word(1, 0, 'h1000, 'h80));
    expect_val("R4 first half period", high_count('h1000, 'h80, 0, 8));
    measure(0, 8, cnt); observe(cnt);
    expect_val("R5 second half period", high_count('h1000, 'h80, 8, 8));
    measure(0, 8, cnt); observe(cnt);

    // R7: new fields without reload leave the waveform alone
    wr('h000, word(1, 0, 'h0800, 'h10));
    expect_val("R7 shadow readback", word(1, 0, 'h0800, 'h10));
    rd('h000, r); observe(r);
    expect_val("R7 waveform unchanged", high_count('h1000, 'h80, 0, 16));
    measure(0, 16, cnt); observe(cnt);

    // R8: reload mid-period, applied at the carry
    wr('h000, word(1, 1, 'h0800, 'h10));
    expect_val("R8 pending while running", word(1, 1, 'h0800, 'h10));
    rd('h000, r); observe(r);
    wait_n = 0;
    while (r[30] && wait_n < 40) begin
      @(negedge clk);
      rd('h000, r);
      wait_n++;
    end
    expect_val("R8 cleared within one period", 1); observe(wait_n <= 16 && wait_n >= 1);
    expect_val("R8 new waveform from boundary", high_count('h0800, 'h10, 0, 32));
    measure(0, 32, cnt); observe(cnt);

    // R5 extremes on channels 1 and 2
    wr('h400, word(0, 1, 'h1000, 'h00));
    wr('h800, word(0, 1, 'h1000, 'hFF));
    wr('h400, word(1, 0, 'h1000, 'h00));
    wr('h800, word(1, 0, 'h1000, 'hFF));
    expect_val("R5 threshold zero always high", 16); measure(1, 16, cnt); observe(cnt);
    expect_val("R5 threshold max always low", 0); measure(2, 16, cnt); observe(cnt);

    // R9: channel 0 untouched by the others
    expect_val("R9 ch0 word intact", word(1, 0, 'h0800, 'h10));
    rd('h000, r); observe(r);
    expect_val("R9 ch0 waveform intact", high_count('h0800, 'h10, 0, 32));
    measure(0, 32, cnt); observe(cnt);

    // R3: off-stride addresses ignored
    wr('h004, 32'hFFFF_FFFF);
    expect_val("R3 off-stride read zero", 0); rd('h004, r); observe(r);
    expect_val("R3 ch0 unchanged", word(1, 0, 'h0800, 'h10));
    rd('h000, r); observe(r);

    // R3/R6: channel 3 at 0xC00, uneven increment
    wr('hC00, word(0, 1, 'h3000, 'h80));
    @(negedge clk);
    expect_val("R3 ch3 readback", word(0, 0, 'h3000, 'h80));
    rd('hC00, r); observe(r);
    wr('hC00, word(1, 0, 'h3000, 'h80));
    expect_val("R6 uneven increment", high_count('h3000, 'h80, 0, 64));
    measure(3, 64, cnt); observe(cnt);

    // R4: switch off then on, phase restarts
    wr('h000, word(0, 0, 'h0800, 'h10));
    expect_val("R4 off low", 0); measure(0, 8, cnt); observe(cnt);
    wr('h000, word(1, 0, 'h0800, 'h10));
    expect_val("R4 restart from zero", high_count('h0800, 'h10, 0, 4));
    measure(0, 4, cnt); observe(cnt);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule